// File: doc/BRIEF.md
# Page-Buffered Byte-Programmable Memory Interface

This block models the device side of a parallel, byte-wide, non-volatile memory that the host drives like an asynchronous static RAM. A select line, a read-enable line and a write-enable line are sampled on the system clock. A write cycle is the span of clock samples in which select and write-enable are both low while read-enable is high. Each write cycle loads one byte into a page buffer. The buffer then waits for a quiet spell before its contents go into the storage array.

Loading is held open by a retriggerable window of `LOAD_CYC` cycles. The start of every write cycle restarts the window. When the window runs out with no write cycle in progress, the block spends `PROG_CYC` cycles programming. At the end of that time it copies every loaded byte into the storage array in one step. During programming, a read of the byte written last returns that byte with bit 7 inverted, so a host can poll for completion. Reads of every other location return the stored contents.

All bytes of one page operation share the page number, which is the address bits above bit 6. Address bits 6:0 pick the byte inside the 128-byte page. The data bus has no tri-state pad. An output-enable flag marks the clock cycles in which the read data would be driven.

Top module: `pgbuf_mem`

## Requirements
- R1: A byte is loaded only by a write cycle, meaning clock samples with `sel_n`=0, `wren_n`=0 and `rden_n`=1. Samples with `rden_n`=0 or `sel_n`=1 load nothing.
- R2: The address of a write cycle is the value on `addr` in its first active sample. Later changes to `addr` within the same cycle have no effect.
- R3: The data of a write cycle is the value on `wdata` in its last active sample.
- R4: One page operation stores from 1 to 128 bytes. Each byte is stored at the address given by the operation's page (`addr[AW-1:7]`) and the byte index `addr[6:0]`. If the same byte is written twice, the later value wins.
- R5: The start of every write cycle outside programming restarts a `LOAD_CYC`-cycle load window. Programming starts only when the window has run out and no write cycle is active. Write cycles spaced closer than the window all land in one operation.
- R6: While bytes are loading, a write cycle to a different page loads nothing. That page keeps its contents.
- R7: While programming, a read of the last loaded address returns that byte with bit 7 inverted and bits 6:0 true. Reads of other addresses return stored data.
- R8: After programming ends, reads return the new bytes. Locations not loaded in the operation keep their old values.
- R9: Write cycles that start during programming change no location.
- R10: `rdata_oe` is 1 in the cycle after a sample with `sel_n`=0, `rden_n`=0 and `wren_n`=1, and 0 after any other sample. `rdata` carries the read value in that same cycle.
- R11: After reset, `rdata_oe` is 0, the block is idle and the page buffer is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Device select, active low |
| rden_n | input | 1 | Read enable, active low |
| wren_n | input | 1 | Write enable, active low |
| addr | input | AW | Byte address; bits 6:0 pick the byte in the page |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (status pattern during programming) |
| rdata_oe | output | 1 | Read data would be driven this cycle |

## Verification
A read result is due one clock edge after the sample that requests it. The bench drives the read at a falling edge and samples `rdata` and `rdata_oe` at the next falling edge. A loaded byte reaches the array about `LOAD_CYC + PROG_CYC` cycles after the last write cycle starts. The bench therefore checks committed data only after waiting 120 cycles. Status reads are placed about 6 cycles after a write cycle, which falls inside the load window, and about 27 cycles after, which falls inside programming. Both points sit well clear of the window edges, so these checks do not depend on the exact cycle on which the state changes.

// File: rtl/pgb_pkg.sv
package pgb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } pgb_state_e;

endpackage

// File: rtl/pgb_strobe.sv
module pgb_strobe #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_n,
  input  logic          rden_n,
  input  logic          wren_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic          cyc_start,
  output logic          cyc_end,
  output logic          cyc_busy,
  output logic [AW-1:0] cyc_addr,
  output logic [7:0]    cyc_data
);

  logic          act;
  logic          act_q;
  logic [AW-1:0] addr_q, addr_d;
  logic [7:0]    data_q, data_d;

  // write cycle: select and write enable low, read enable high
  assign act       = !sel_n && !wren_n && rden_n;
  assign cyc_start = act && !act_q;
  assign cyc_end   = !act && act_q;
  assign cyc_busy  = act_q;
  assign cyc_addr  = addr_q;
  assign cyc_data  = data_q;

  always_comb begin
    addr_d = addr_q;
    data_d = data_q;
    if (cyc_start) addr_d = addr;
    if (act)       data_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      act_q  <= act;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && act) |=> $stable(addr_q)) else $error("address moved inside cycle"); // R2

  AST_END_AFTER_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end |-> $past(act)) else $error("cycle end without active sample"); // R1

endmodule

// File: rtl/pgb_timer.sv
module pgb_timer
  import pgb_pkg::*;
#(
  parameter int LOAD_CYC = 16,
  parameter int PROG_CYC = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       hold,
  output pgb_state_e state,
  output logic       commit
);

  localparam int MAXC = (LOAD_CYC > PROG_CYC) ? LOAD_CYC : PROG_CYC;
  localparam int CW   = $clog2(MAXC) + 1;
  localparam logic [CW-1:0] LOAD_TOP = CW'(LOAD_CYC - 1);
  localparam logic [CW-1:0] PROG_TOP = CW'(PROG_CYC - 1);

  pgb_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign state  = st_q;
  assign commit = (st_q == ST_PROG) && (cnt_q == '0);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_IDLE: begin
        if (restart) begin
          st_d  = ST_LOAD;
          cnt_d = LOAD_TOP;
        end
      end
      ST_LOAD: begin
        if (restart) begin
          cnt_d = LOAD_TOP;
        end else if (cnt_q != '0) begin
          cnt_d = cnt_q - 1'b1;
        end else if (!hold) begin
          st_d  = ST_PROG;
          cnt_d = PROG_TOP;
        end
      end
      ST_PROG: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - 1'b1;
        end else begin
          st_d = ST_IDLE;
        end
      end
      default: begin
        st_d  = ST_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  AST_LOAD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOAD) |-> (cnt_q <= LOAD_TOP)) else $error("load count range"); // R5

  AST_PROG_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOAD && restart) |=> (st_q == ST_LOAD)) else $error("program began despite restart"); // R5

  AST_COMMIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (st_q == ST_IDLE)) else $error("no idle after commit"); // R8

endmodule

// File: rtl/pgb_pagebuf.sv
module pgb_pagebuf #(
  parameter int PW = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [PW-1:0]        wr_idx,
  input  logic [7:0]           wr_data,
  input  logic                 clr,
  output logic [(1<<PW)-1:0][7:0] pg_data,
  output logic [(1<<PW)-1:0]   pg_vld
);

  localparam int NB = 1 << PW;

  logic [NB-1:0] vld_q, vld_d;
  logic [NB-1:0] hit;

  for (genvar g = 0; g < NB; g++) begin : g_slot
    assign hit[g] = wr_en && (wr_idx == PW'(g));

    logic [7:0] byte_q;
    always_ff @(posedge clk) begin
      if (hit[g]) byte_q <= wr_data;
    end
    assign pg_data[g] = byte_q;
  end

  always_comb begin
    vld_d = vld_q;
    if (clr) vld_d = '0;
    vld_d = vld_d | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  assign pg_vld = vld_q;

  AST_NO_LOAD_ON_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr && wr_en)) else $error("load during commit"); // R9

  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (vld_q == '0)) else $error("buffer not emptied"); // R8

endmodule

// File: rtl/pgb_array.sv
module pgb_array #(
  parameter int AW = 10,
  parameter int PW = 7
) (
  input  logic                    clk,
  input  logic                    commit,
  input  logic [AW-PW-1:0]        tag,
  input  logic [(1<<PW)-1:0][7:0] pg_data,
  input  logic [(1<<PW)-1:0]      pg_vld,
  input  logic [AW-1:0]           rd_addr,
  output logic [7:0]              rd_data
);

  localparam int NB = 1 << PW;
  localparam int NP = 1 << (AW - PW);

  logic [7:0] mem [NP][NB];

  always_ff @(posedge clk) begin
    if (commit) begin
      for (int k = 0; k < NB; k++) begin
        if (pg_vld[k]) mem[tag][k] <= pg_data[k];
      end
    end
  end

  assign rd_data = mem[rd_addr[AW-1:PW]][rd_addr[PW-1:0]];

endmodule

// File: rtl/pgbuf_mem.sv
module pgbuf_mem
  import pgb_pkg::*;
#(
  parameter int AW       = 10,
  parameter int LOAD_CYC = 16,
  parameter int PROG_CYC = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_n,
  input  logic          rden_n,
  input  logic          wren_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          rdata_oe
);

  localparam int PW = 7;
  localparam int NB = 1 << PW;
  localparam int TW = AW - PW;

  // reset: asserted asynchronously, released on the clock
  logic rst_m, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_i <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_i <= rst_m;
    end
  end

  logic          cyc_start, cyc_end, cyc_busy;
  logic [AW-1:0] cyc_addr;
  logic [7:0]    cyc_data;

  pgb_strobe #(.AW(AW)) i_strobe (
    .clk      (clk),
    .rst_n    (rst_i),
    .sel_n    (sel_n),
    .rden_n   (rden_n),
    .wren_n   (wren_n),
    .addr     (addr),
    .wdata    (wdata),
    .cyc_start(cyc_start),
    .cyc_end  (cyc_end),
    .cyc_busy (cyc_busy),
    .cyc_addr (cyc_addr),
    .cyc_data (cyc_data)
  );

  pgb_state_e state;
  logic       commit;
  logic       restart;

  assign restart = cyc_start && (state != ST_PROG);

  pgb_timer #(.LOAD_CYC(LOAD_CYC), .PROG_CYC(PROG_CYC)) i_timer (
    .clk    (clk),
    .rst_n  (rst_i),
    .restart(restart),
    .hold   (cyc_busy),
    .state  (state),
    .commit (commit)
  );

  // page tag and per-cycle acceptance
  logic [TW-1:0] tag_q, tag_d;
  logic          acc_q, acc_d;
  logic          buf_we;

  always_comb begin
    tag_d = tag_q;
    acc_d = acc_q;
    if (cyc_start) begin
      unique case (state)
        ST_IDLE: begin
          tag_d = addr[AW-1:PW];
          acc_d = 1'b1;
        end
        ST_LOAD: acc_d = (addr[AW-1:PW] == tag_q);
        default: acc_d = 1'b0;
      endcase
    end else if (cyc_end) begin
      acc_d = 1'b0;
    end
  end

  assign buf_we = cyc_end && acc_q;

  // last loaded byte, used for the busy pattern
  logic [AW-1:0] lw_addr_q, lw_addr_d;
  logic [7:0]    lw_data_q, lw_data_d;

  always_comb begin
    lw_addr_d = lw_addr_q;
    lw_data_d = lw_data_q;
    if (buf_we) begin
      lw_addr_d = cyc_addr;
      lw_data_d = cyc_data;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      tag_q     <= '0;
      acc_q     <= 1'b0;
      lw_addr_q <= '0;
      lw_data_q <= '0;
    end else begin
      tag_q     <= tag_d;
      acc_q     <= acc_d;
      lw_addr_q <= lw_addr_d;
      lw_data_q <= lw_data_d;
    end
  end

  logic [NB-1:0][7:0] pg_data;
  logic [NB-1:0]      pg_vld;

  pgb_pagebuf #(.PW(PW)) i_pagebuf (
    .clk    (clk),
    .rst_n  (rst_i),
    .wr_en  (buf_we),
    .wr_idx (cyc_addr[PW-1:0]),
    .wr_data(cyc_data),
    .clr    (commit),
    .pg_data(pg_data),
    .pg_vld (pg_vld)
  );

  logic [7:0] arr_rd;

  pgb_array #(.AW(AW), .PW(PW)) i_array (
    .clk    (clk),
    .commit (commit),
    .tag    (tag_q),
    .pg_data(pg_data),
    .pg_vld (pg_vld),
    .rd_addr(addr),
    .rd_data(arr_rd)
  );

  // read path, registered
  logic       rd_req;
  logic [7:0] rd_val;
  logic [7:0] rdata_q, rdata_d;
  logic       oe_q;

  assign rd_req = !sel_n && !rden_n && wren_n;

  always_comb begin
    rd_val = arr_rd;
    if ((state == ST_PROG) && (addr == lw_addr_q)) begin
      rd_val = {~lw_data_q[7], lw_data_q[6:0]};
    end
    rdata_d = rd_req ? rd_val : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      rdata_q <= '0;
      oe_q    <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      oe_q    <= rd_req;
    end
  end

  assign rdata    = rdata_q;
  assign rdata_oe = oe_q;

  AST_PROG_IGNORE: assert property (@(posedge clk) disable iff (!rst_i)
    (state == ST_PROG) |-> !buf_we) else $error("load during programming"); // R9

  AST_SAME_PAGE: assert property (@(posedge clk) disable iff (!rst_i)
    buf_we |-> (cyc_addr[AW-1:PW] == tag_q)) else $error("foreign page loaded"); // R6

  AST_RD_OE_ON: assert property (@(posedge clk) disable iff (!rst_i)
    (!sel_n && !rden_n && wren_n) |=> rdata_oe) else $error("output not enabled"); // R10

  AST_RD_OE_OFF: assert property (@(posedge clk) disable iff (!rst_i)
    !(!sel_n && !rden_n && wren_n) |=> !rdata_oe) else $error("output enabled"); // R10

  AST_PROG_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_i)
    commit |-> (pg_vld != '0)) else $error("commit of empty page"); // R4

endmodule

// File: tb/test_pgbuf_mem.sv
module test_pgbuf_mem;

  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sel_n, rden_n, wren_n;
  logic [AW-1:0] addr;
  logic [7:0]    wdata;
  logic [7:0]    rdata;
  logic          rdata_oe;

  int nchk = 0;
  int nbad = 0;

  logic [7:0] em [0:1023];

  always #4 clk = ~clk;

  pgbuf_mem #(.AW(AW), .LOAD_CYC(16), .PROG_CYC(64)) i_pgbuf_mem (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rden_n(rden_n), .wren_n(wren_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  function automatic logic [7:0] fill_val(int a);
    return 8'((a * 37 + 11) ^ (a >> 3));
  endfunction

  function automatic logic [7:0] poll_val(logic [7:0] d);
    return {~d[7], d[6:0]};
  endfunction

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    nchk++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s got=%02h exp=%02h", req, got, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk);
    addr = AW'(a); wdata = d; sel_n = 0; wren_n = 0; rden_n = 1;
    @(negedge clk);
    @(negedge clk);
    sel_n = 1; wren_n = 1;
  endtask

  task automatic rd(int a, output logic [7:0] v, output logic oe);
    @(negedge clk);
    addr = AW'(a); sel_n = 0; rden_n = 0; wren_n = 1;
    @(negedge clk);
    v = rdata; oe = rdata_oe;
    sel_n = 1; rden_n = 1;
  endtask

  task automatic rd_chk(string req, int a, logic [7:0] exp);
    logic [7:0] v;
    logic oe;
    rd(a, v, oe);
    check({req, " oe"}, {7'd0, oe}, 8'd1);
    check(req, v, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic oe;
    int pg, n, base;
    int oa [8];
    logic [7:0] od [8];
    void'($urandom(32'd4711));
    rst_n = 0; sel_n = 1; rden_n = 1; wren_n = 1; addr = '0; wdata = '0;
    idle(3);
    rst_n = 1;
    idle(4);

    // R11: reset state
    check("R11 oe after reset", {7'd0, rdata_oe}, 8'd0);
    @(negedge clk); addr = 0; sel_n = 1; rden_n = 0; wren_n = 1;
    @(negedge clk); check("R10 oe off when unselected", {7'd0, rdata_oe}, 8'd0);
    rden_n = 1;

    // R4: full 128-byte pages 0..3
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 128; i++) wr(p * 128 + i, fill_val(p * 128 + i));
      idle(120);
      for (int i = 0; i < 128; i++) em[p * 128 + i] = fill_val(p * 128 + i);
    end
    for (int i = 0; i < 512; i += 5) rd_chk("R4 full page", i, em[i]);
    rd_chk("R4 page end", 511, em[511]);

    // R7, R8, R9: single write, status during programming
    wr(2, 8'h3C);
    idle(4);
    rd_chk("R5 old data while loading", 2, em[2]);
    idle(20);
    rd_chk("R7 inverted bit 7", 2, poll_val(8'h3C));
    rd_chk("R7 other address true", 1, em[1]);
    wr(300, 8'h99);                       // R9: ignored during programming
    idle(120);
    em[2] = 8'h3C;
    rd_chk("R8 new data", 2, 8'h3C);
    rd_chk("R9 ignored write", 300, em[300]);
    rd_chk("R8 neighbour kept", 3, em[3]);

    // R5: retrigger, writes spaced 10 idle cycles apart
    for (int i = 0; i < 5; i++) begin
      wr(16 + i, 8'hA0 + 8'(i));
      idle(10);
    end
    rd_chk("R5 last still loading", 20, em[20]);
    idle(120);
    for (int i = 0; i < 5; i++) begin
      em[16 + i] = 8'hA0 + 8'(i);
      rd_chk("R5 retriggered bytes", 16 + i, em[16 + i]);
    end

    // R6: other page during load ignored
    wr(40, 8'h11);
    wr(200, 8'h22);
    wr(41, 8'h33);
    idle(120);
    em[40] = 8'h11; em[41] = 8'h33;
    rd_chk("R6 other page kept", 200, em[200]);
    rd_chk("R6 same page stored", 41, 8'h33);

    // R1: strobes with read enable low or select high do nothing
    @(negedge clk); addr = 50; wdata = 8'h5A; sel_n = 0; wren_n = 0; rden_n = 0;
    idle(2); sel_n = 1; wren_n = 1; rden_n = 1;
    @(negedge clk); addr = 51; wdata = 8'h5B; sel_n = 1; wren_n = 0;
    idle(2); wren_n = 1;
    idle(120);
    rd_chk("R1 read-enable low ignored", 50, em[50]);
    rd_chk("R1 unselected ignored", 51, em[51]);

    // R2, R3: address from first sample, data from last sample
    @(negedge clk); addr = 60; wdata = 8'h01; sel_n = 0; wren_n = 0; rden_n = 1;
    @(negedge clk); addr = 61; wdata = 8'h02;
    @(negedge clk); wdata = 8'hE7;
    @(negedge clk); sel_n = 1; wren_n = 1;
    idle(120);
    em[60] = 8'hE7;
    rd_chk("R2 first address", 60, 8'hE7);
    rd_chk("R2 later address kept", 61, em[61]);
    rd_chk("R3 last data", 60, 8'hE7);

    // random page operations
    for (int t = 0; t < 40; t++) begin
      pg = int'($urandom_range(3, 0));
      n = int'($urandom_range(6, 1));
      base = pg * 128;
      for (int i = 0; i < n; i++) begin
        oa[i] = base + int'($urandom_range(127, 0));
        od[i] = 8'($urandom);
        wr(oa[i], od[i]);
      end
      idle(6);
      rd(oa[n-1], v, oe);
      check("R5 random load window", v, em[oa[n-1]]);
      idle(16);
      rd(oa[n-1], v, oe);
      check("R7 random poll", v, poll_val(od[n-1]));
      idle(100);
      for (int i = 0; i < n; i++) em[oa[i]] = od[i];
      for (int i = 0; i < n; i++) rd_chk("R4 random readback", oa[i], em[oa[i]]);
      begin
        int ra;
        ra = int'($urandom_range(511, 0));
        rd_chk("R8 random untouched", ra, em[ra]);
      end
    end

    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

endmodule